// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home-node directory for a range of memory blocks shared by a fixed set of nodes that talk through point-to-point messages. For every block it holds a three-way state (Uncached, Shared, Exclusive) and a presence vector with one bit per node. Requesting nodes send it read misses, write misses and data write-backs. In response it sends data replies, invalidations to sharers and fetch requests to owners. It counts the invalidation acknowledgements that come back and takes in the data that owners return. It reads and writes the node's local memory through a simple synchronous port.

The controller serves one transaction at a time. A request is latched and then looked up in the directory on the next cycle. If other caches must be invalidated or the owner must give up its copy, the controller sends those messages and waits for the answers. After that it sends the data reply and updates the entry. While it waits, it refuses any new request. Only the answers it is waiting for are accepted.

Top module: `dir_home_top`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector, no outgoing message is valid, and a request message is accepted (inReady high for inType 0, 1 or 2).
- R2: A read miss (inType 0) to an Uncached block produces one data reply (outType 0) to the requester carrying the memory value; the block becomes Shared with only the requester present.
- R3: A write miss (inType 1) to an Uncached block produces a data reply with the memory value and makes the requester the sole Exclusive owner.
- R4: A read miss to a Shared block produces a data reply with the memory value and adds the requester to the presence vector, with no invalidation or fetch sent.
- R5: A write miss to a Shared block sends exactly one invalidation (outType 1) to each other present node, one per cycle, never to the requester. The data reply comes only after an acknowledgement (inType 3) has been received for every invalidation. The requester then becomes the sole Exclusive owner.
- R6: A read miss to a block owned Exclusive by another node sends a share-fetch (outType 2) to the owner. The data the owner returns (inType 4) is written to memory and forwarded to the requester, and the block becomes Shared with both nodes present.
- R7: A write miss to a block owned Exclusive by another node sends an invalidating fetch (outType 3) to the owner. The returned data is written to memory and forwarded to the requester, which becomes the new sole owner while the block stays Exclusive.
- R8: A write-back (inType 2) from the Exclusive owner writes its data to memory and returns the block to Uncached, with no outgoing message.
- R9: A write-back from a node that is not the Exclusive owner is ignored: memory is not written, no message is sent and the entry is unchanged.
- R10: While a transaction is in progress, new request messages are refused (inReady low); only the awaited acknowledgement or owner data is accepted.
- R11: A read or write miss from the node already recorded as Exclusive owner is served from memory without a fetch. A read leaves the block Shared with that node; a write keeps it Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Incoming message valid |
| inReady | output | 1 | Incoming message accepted this cycle |
| inType | input | 3 | 0 read miss, 1 write miss, 2 write-back, 3 invalidation ack, 4 owner data |
| inSrc | input | NODE_W | Sending node |
| inAddr | input | ADDR_W | Block index of the request |
| inData | input | DATA_W | Data of a write-back or owner data |
| outValid | output | 1 | Outgoing message valid |
| outType | output | 2 | 0 data reply, 1 invalidate, 2 share-fetch, 3 invalidating fetch |
| outDst | output | NODE_W | Destination node |
| outAddr | output | ADDR_W | Block index of the message |
| outData | output | DATA_W | Data of a reply, zero otherwise |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory block index |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data for memAddr, same cycle |

## Verification
The assertions assume well-behaved nodes. An acknowledgement comes only from a node that was actually invalidated, at most once per invalidation. Owner data comes only after a fetch. The memory read port returns the addressed word combinationally. The bench's node models follow these rules: they acknowledge each invalidation once and return owner data one cycle after a fetch. They never send unsolicited answers. The only out-of-turn stimulus is a request presented during a fetch, which the design must refuse.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  typedef enum logic [2:0] {
    IN_RDMISS    = 3'd0,
    IN_WRMISS    = 3'd1,
    IN_WBACK     = 3'd2,
    IN_INVACK    = 3'd3,
    IN_FETCHDATA = 3'd4
  } inMsg_t;

  typedef enum logic [1:0] {
    OUT_DATA     = 2'd0,
    OUT_INV      = 2'd1,
    OUT_FETCHSH  = 2'd2,
    OUT_FETCHINV = 2'd3
  } outMsg_t;

  typedef enum logic [1:0] {
    ENT_UNCACHED = 2'd0,
    ENT_SHARED   = 2'd1,
    ENT_EXCL     = 2'd2
  } entState_t;

  typedef enum logic [2:0] {
    C_IDLE, C_LOOK, C_INVAL, C_WAITACK, C_FETCH, C_WAITDATA, C_REPLY
  } ctrlState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic latchReq;
    logic loadInv;
    logic sendInv;
    logic takeAck;
    logic takeFetch;
    logic wbCommit;
    logic replyCommit;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    inMsg_t    reqType;
    entState_t entState;
    logic      invNone;
    logic      ownerIsSrc;
    logic      pendLast;
    logic      outZero;
    logic      inFromOwner;
  } dpStatus_t;

endpackage

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  inType,
  input  dpStatus_t   status,
  output logic        inReady,
  output ctrlStrobe_t stb,
  output logic        outValid,
  output outMsg_t     outKind,
  output ctrlState_t  stateOut
);

  ctrlState_t state, stateNext;
  logic accept;

  always_comb begin
    unique case (state)
      C_IDLE:            inReady = (inType == IN_RDMISS) || (inType == IN_WRMISS) || (inType == IN_WBACK);
      C_INVAL, C_WAITACK: inReady = (inType == IN_INVACK);
      C_WAITDATA:        inReady = (inType == IN_FETCHDATA) && status.inFromOwner;
      default:           inReady = 1'b0;
    endcase
  end

  assign accept = inValid && inReady;

  always_comb begin
    stb       = '0;
    outValid  = 1'b0;
    outKind   = OUT_DATA;
    stateNext = state;
    unique case (state)
      C_IDLE: begin
        stb.latchReq = accept;
        if (accept) stateNext = C_LOOK;
      end
      C_LOOK: begin
        if (status.reqType == IN_WBACK) begin
          stb.wbCommit = (status.entState == ENT_EXCL) && status.ownerIsSrc;
          stateNext    = C_IDLE;
        end else begin
          unique case (status.entState)
            ENT_SHARED: begin
              if (status.reqType == IN_WRMISS && !status.invNone) begin
                stb.loadInv = 1'b1;
                stateNext   = C_INVAL;
              end else begin
                stateNext = C_REPLY;
              end
            end
            ENT_EXCL: stateNext = status.ownerIsSrc ? C_REPLY : C_FETCH;
            default:  stateNext = C_REPLY;
          endcase
        end
      end
      C_INVAL: begin
        outValid    = 1'b1;
        outKind     = OUT_INV;
        stb.sendInv = 1'b1;
        stb.takeAck = accept;
        if (status.pendLast) stateNext = C_WAITACK;
      end
      C_WAITACK: begin
        stb.takeAck = accept;
        if (status.outZero) stateNext = C_REPLY;
      end
      C_FETCH: begin
        outValid  = 1'b1;
        outKind   = (status.reqType == IN_RDMISS) ? OUT_FETCHSH : OUT_FETCHINV;
        stateNext = C_WAITDATA;
      end
      C_WAITDATA: begin
        stb.takeFetch = accept;
        if (accept) stateNext = C_REPLY;
      end
      C_REPLY: begin
        outValid        = 1'b1;
        outKind         = OUT_DATA;
        stb.replyCommit = 1'b1;
        stateNext       = C_IDLE;
      end
      default: stateNext = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= C_IDLE;
    else       state <= stateNext;
  end

  assign stateOut = state;

endmodule

// File: rtl/dir_home_dp.sv
module dir_home_dp
  import dir_home_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = $clog2(BLOCKS),
  localparam int CNT_W  = $clog2(NODES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  outMsg_t           outKind,
  input  logic [2:0]        inType,
  input  logic [NODE_W-1:0] inSrc,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] memRdata,
  output dpStatus_t         status,
  output logic [NODE_W-1:0] outDst,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [NODE_W-1:0] reqSrc,
  output logic [NODES-1:0]  entVec,
  output logic [CNT_W-1:0]  outCnt
);

  function automatic logic [NODE_W-1:0] lowestIdx(input logic [NODES-1:0] v);
    lowestIdx = '0;
    for (int i = NODES - 1; i >= 0; i--)
      if (v[i]) lowestIdx = NODE_W'(i);
  endfunction

  inMsg_t            reqType;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqData;
  logic [NODES-1:0]  pendMask;
  logic [NODES-1:0]  srcBit;
  logic [NODE_W-1:0] ownerIdx, invDst;
  entState_t         stArr  [BLOCKS];
  logic [NODES-1:0]  vecArr [BLOCKS];
  entState_t         entState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqType <= IN_RDMISS;
      reqSrc  <= '0;
      reqAddr <= '0;
      reqData <= '0;
    end else if (stb.latchReq) begin
      reqType <= inMsg_t'(inType);
      reqSrc  <= inSrc;
      reqAddr <= inAddr;
      reqData <= inData;
    end
  end

  assign srcBit   = NODES'(1) << reqSrc;
  assign entState = stArr[reqAddr];
  assign entVec   = vecArr[reqAddr];
  assign ownerIdx = lowestIdx(entVec);
  assign invDst   = lowestIdx(pendMask);

  for (genvar b = 0; b < BLOCKS; b++) begin : g_entry
    entState_t        st;
    logic [NODES-1:0] vec;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st  <= ENT_UNCACHED;
        vec <= '0;
      end else if (reqAddr == ADDR_W'(b)) begin
        if (stb.wbCommit) begin
          st  <= ENT_UNCACHED;
          vec <= '0;
        end else if (stb.replyCommit) begin
          if (reqType == IN_RDMISS) begin
            st  <= ENT_SHARED;
            vec <= vec | srcBit;
          end else begin
            st  <= ENT_EXCL;
            vec <= srcBit;
          end
        end
      end
    end
    assign stArr[b]  = st;
    assign vecArr[b] = vec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
      outCnt   <= '0;
    end else begin
      if (stb.loadInv)      pendMask <= entVec & ~srcBit;
      else if (stb.sendInv) pendMask <= pendMask & ~(NODES'(1) << invDst);
      outCnt <= outCnt + CNT_W'(stb.sendInv) - CNT_W'(stb.takeAck);
    end
  end

  assign status.reqType     = reqType;
  assign status.entState    = entState;
  assign status.invNone     = (entVec & ~srcBit) == '0;
  assign status.ownerIsSrc  = entVec[reqSrc];
  assign status.pendLast    = (pendMask & (pendMask - NODES'(1))) == '0;
  assign status.outZero     = (outCnt == '0);
  assign status.inFromOwner = (inSrc == ownerIdx);

  assign memAddr  = reqAddr;
  assign memWe    = stb.takeFetch | stb.wbCommit;
  assign memWdata = stb.takeFetch ? inData : reqData;

  assign outAddr = reqAddr;
  assign outData = (outKind == OUT_DATA) ? memRdata : '0;
  always_comb begin
    unique case (outKind)
      OUT_DATA: outDst = reqSrc;
      OUT_INV:  outDst = invDst;
      default:  outDst = ownerIdx;
    endcase
  end

endmodule

// File: rtl/dir_home_top.sv
module dir_home_top
  import dir_home_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int ADDR_W = $clog2(BLOCKS),
  localparam int CNT_W  = $clog2(NODES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inType,
  input  logic [NODE_W-1:0] inSrc,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [1:0]        outType,
  output logic [NODE_W-1:0] outDst,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  ctrlStrobe_t       stb;
  dpStatus_t         dpStatus;
  outMsg_t           outKind;
  ctrlState_t        ctrlState;
  logic [NODE_W-1:0] reqSrc;
  logic [NODES-1:0]  entVec;
  logic [CNT_W-1:0]  outCnt;

  dir_home_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inType   (inType),
    .status   (dpStatus),
    .inReady  (inReady),
    .stb      (stb),
    .outValid (outValid),
    .outKind  (outKind),
    .stateOut (ctrlState)
  );

  dir_home_dp #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .outKind  (outKind),
    .inType   (inType),
    .inSrc    (inSrc),
    .inAddr   (inAddr),
    .inData   (inData),
    .memRdata (memRdata),
    .status   (dpStatus),
    .outDst   (outDst),
    .outAddr  (outAddr),
    .outData  (outData),
    .memWe    (memWe),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .reqSrc   (reqSrc),
    .entVec   (entVec),
    .outCnt   (outCnt)
  );

  assign outType = outKind;

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk
  import dir_home_pkg::*;
#(
  parameter int NODES = 4,
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W  = $clog2(NODES + 1)
)(
  input logic              clk,
  input logic              rstN,
  input ctrlState_t        ctrlState,
  input logic              inValid,
  input logic              inReady,
  input logic [2:0]        inType,
  input logic              outValid,
  input logic [1:0]        outType,
  input logic [NODE_W-1:0] outDst,
  input logic [NODE_W-1:0] reqSrc,
  input entState_t         entState,
  input logic [NODES-1:0]  entVec,
  input logic [CNT_W-1:0]  outCnt,
  input logic              memWe
);

  // R10: in a transaction only awaited answers get through
  a_r10_busy_refuse: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState != C_IDLE && inValid && inReady) |-> (inType == IN_INVACK || inType == IN_FETCHDATA));

  // R5: never invalidate the requester
  a_r5_no_self_inv: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType == OUT_INV) |-> (outDst != reqSrc));

  // R5: reply waits for every acknowledgement
  a_r5_acks_before_reply: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType == OUT_DATA) |-> (outCnt == '0));

  // R3: an exclusive entry has exactly one owner
  a_r3_excl_one_owner: assert property (@(posedge clk) disable iff (!rstN)
    (entState == ENT_EXCL) |-> ($countones(entVec) == 1));

  // R2: a shared entry has at least one sharer
  a_r2_shared_has_sharer: assert property (@(posedge clk) disable iff (!rstN)
    (entState == ENT_SHARED) |-> (entVec != '0));

  // R1: an uncached entry has no sharers
  a_r1_uncached_empty: assert property (@(posedge clk) disable iff (!rstN)
    (entState == ENT_UNCACHED) |-> (entVec == '0));

  // R8: a write-back commit is silent
  a_r8_wb_silent: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && ctrlState == C_LOOK) |-> !outValid);

endmodule

bind dir_home_top dir_home_chk #(.NODES(NODES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlState (ctrlState),
  .inValid   (inValid),
  .inReady   (inReady),
  .inType    (inType),
  .outValid  (outValid),
  .outType   (outType),
  .outDst    (outDst),
  .reqSrc    (reqSrc),
  .entState  (dpStatus.entState),
  .entVec    (entVec),
  .outCnt    (outCnt),
  .memWe     (memWe)
);

// File: tb/test_dir_home_top.sv
module test_dir_home_top;
  localparam int NODES = 4, BLOCKS = 8, DW = 16, NW = 2, AW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [2:0] inType = '0;
  logic [NW-1:0] inSrc = '0;
  logic [AW-1:0] inAddr = '0;
  logic [DW-1:0] inData = '0;
  logic outValid;
  logic [1:0] outType;
  logic [NW-1:0] outDst;
  logic [AW-1:0] outAddr;
  logic [DW-1:0] outData;
  logic memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  always #4 clk = ~clk;

  dir_home_top #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DW)) i_dir_home_top (.*);

  logic [DW-1:0] mem [BLOCKS];
  assign memRdata = mem[memAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BLOCKS; i++) mem[i] <= DW'(16'hA000 + i);
    end else if (memWe) mem[memAddr] <= memWdata;
  end

  int total = 0, bad = 0;
  bit finished = 0;
  int refSt [BLOCKS];
  logic [NODES-1:0] refVec [BLOCKS];
  logic [DW-1:0] refMem [BLOCKS];
  logic [DW-1:0] nodeVal [NODES][BLOCKS];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NODES-1:0] v);
    lowest = 0;
    for (int i = NODES - 1; i >= 0; i--) if (v[i]) lowest = i;
  endfunction

  task automatic doTxn(input int kind, input int src, input int addr, input logic [DW-1:0] wd);
    int st, owner, expFetchType, expFetchDst, fetchType, fetchDst, repDst;
    logic [NODES-1:0] vec, expInv, seenInv, ackMask;
    logic [DW-1:0] expData, repData;
    bit gotReply, gotFetch, probe, fetchDue, extraMsg;
    string tag;
    st = refSt[addr]; vec = refVec[addr]; owner = lowest(vec);
    expInv = '0; expFetchType = -1; expFetchDst = -1; expData = '0;
    if (kind == 2) begin
      if (st == 2 && vec[src]) begin
        tag = "R8"; refMem[addr] = wd; refSt[addr] = 0; refVec[addr] = '0;
      end else tag = "R9";
    end else begin
      if (st == 0) tag = (kind == 0) ? "R2" : "R3";
      else if (st == 1) tag = (kind == 0) ? "R4" : "R5";
      else if (vec[src]) tag = "R11";
      else tag = (kind == 0) ? "R6" : "R7";
      if (st == 2 && !vec[src]) begin
        expFetchType = (kind == 0) ? 2 : 3; expFetchDst = owner;
        refMem[addr] = nodeVal[owner][addr];
      end
      if (st == 1 && kind == 1) expInv = vec & ~(NODES'(1) << src);
      expData = refMem[addr];
      if (kind == 0) begin refSt[addr] = 1; refVec[addr] = vec | (NODES'(1) << src); end
      else begin refSt[addr] = 2; refVec[addr] = NODES'(1) << src; nodeVal[src][addr] = wd; end
    end

    @(negedge clk);
    inValid = 1'b1; inType = 3'(kind); inSrc = NW'(src); inAddr = AW'(addr); inData = wd;
    #1 check(inReady == 1'b1, "R10", "idle request accepted", int'(inReady), 1);

    seenInv = '0; ackMask = '0; gotReply = 0; gotFetch = 0; probe = 0; fetchDue = 0; extraMsg = 0;
    fetchType = -1; fetchDst = -1; repDst = -1; repData = '0;
    for (int cyc = 0; cyc < 40 && !gotReply; cyc++) begin
      @(negedge clk);
      inValid = 1'b0;
      if (outValid) begin
        if (outAddr != AW'(addr)) extraMsg = 1;
        if (outType == 2'd1) begin
          if (seenInv[outDst]) extraMsg = 1;
          seenInv[outDst] = 1'b1; ackMask[outDst] = 1'b1;
        end else if (outType == 2'd0) begin
          gotReply = 1; repDst = int'(outDst); repData = outData;
        end else begin
          if (gotFetch) extraMsg = 1;
          gotFetch = 1; fetchType = int'(outType); fetchDst = int'(outDst); probe = 1;
        end
      end
      if (kind == 2 && cyc >= 5) break;
      if (probe) begin
        inValid = 1'b1; inType = 3'd0; inSrc = NW'(src); inAddr = AW'(addr);
        #1 check(inReady == 1'b0, "R10", "request refused while fetching", int'(inReady), 0);
        inValid = 1'b0; probe = 0; fetchDue = 1;
      end else if (fetchDue) begin
        inValid = 1'b1; inType = 3'd4; inSrc = NW'(fetchDst); inAddr = AW'(addr);
        inData = nodeVal[fetchDst][addr]; fetchDue = 0;
      end else if (ackMask != '0) begin
        inValid = 1'b1; inType = 3'd3; inSrc = NW'(lowest(ackMask)); inAddr = AW'(addr);
        ackMask[lowest(ackMask)] = 1'b0;
      end
    end
    inValid = 1'b0;

    if (kind == 2) begin
      check(!gotReply && !gotFetch && seenInv == '0, tag, "write-back sends nothing", int'(gotReply), 0);
    end else begin
      check(gotReply, tag, "data reply seen", int'(gotReply), 1);
      check(repDst == src, tag, "reply destination", repDst, src);
      check(repData == expData, tag, "reply data", int'(repData), int'(expData));
      check(seenInv == expInv, tag, "invalidation set", int'(seenInv), int'(expInv));
      check(fetchType == expFetchType, tag, "fetch type", fetchType, expFetchType);
      check(fetchDst == expFetchDst, tag, "fetch destination", fetchDst, expFetchDst);
    end
    check(!extraMsg, tag, "no stray message", int'(extraMsg), 0);
    check(mem[addr] == refMem[addr], tag, "memory content", int'(mem[addr]), int'(refMem[addr]));
  endtask

  initial begin
    for (int b = 0; b < BLOCKS; b++) begin
      refSt[b] = 0; refVec[b] = '0; refMem[b] = DW'(16'hA000 + b);
      for (int n = 0; n < NODES; n++) nodeVal[n][b] = '0;
    end
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    inType = 3'd0;
    #1;
    check(outValid == 1'b0, "R1", "no message after reset", int'(outValid), 0);
    check(inReady == 1'b1, "R1", "request accepted after reset", int'(inReady), 1);
    check(memWe == 1'b0, "R1", "no memory write after reset", int'(memWe), 0);

    doTxn(0, 0, 0, 16'h0);      // R2
    doTxn(0, 1, 0, 16'h0);      // R4
    doTxn(0, 2, 0, 16'h0);      // R4
    doTxn(1, 3, 0, 16'h1111);   // R5: invalidate 0,1,2
    doTxn(0, 0, 0, 16'h0);      // R6: fetch from 3
    doTxn(1, 0, 0, 16'h2222);   // R5: requester present, only 3 invalidated
    doTxn(1, 2, 0, 16'h3333);   // R7: fetch from 0
    doTxn(2, 1, 0, 16'h4444);   // R9: not owner
    doTxn(2, 2, 0, 16'h5555);   // R8
    doTxn(1, 1, 1, 16'h6666);   // R3
    doTxn(1, 1, 1, 16'h6767);   // R11 write from owner
    doTxn(0, 1, 1, 16'h0);      // R11 read from owner
    doTxn(2, 3, 2, 16'h7777);   // R9: uncached block
    doTxn(0, 0, 0, 16'h0);      // R2 again after write-back

    for (int t = 0; t < 600; t++) begin
      int r, k;
      r = int'($urandom_range(0, 9));
      k = (r < 4) ? 0 : (r < 8) ? 1 : 2;
      doTxn(k, int'($urandom_range(0, NODES - 1)), int'($urandom_range(0, BLOCKS - 1)),
            DW'($urandom_range(0, 65535)));
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule